// File: doc/BRIEF.md
# Pixel-Clock Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a raster display, together with a pixel path that substitutes a programmable fill colour whenever the upstream source has nothing to give inside the visible area. Horizontal timing is described in pixels within a line. Every vertical quantity (frame length, vsync length, first and last visible position) is an absolute count of pixel clocks from the start of the frame, not a count of lines.

Software programs the block through a single-cycle write port. Timing and polarity settings are written into shadow copies and move into the working set only at a frame boundary, so a frame is never drawn with half-old, half-new timing. The enable bit is also sampled only at a frame boundary: starting waits for the engine to be idle, and stopping lets the current frame finish. A frame counter and a line counter, each with its own enable bit, give the position of the scan.

Top module: `pixclk_timing_gen`

## Requirements
- R1: After reset the engine is idle, hsync, vsync, de, pix_sel and pix_out are 0, both counters are 0 and the fill colour is 0xFF.
- R2: Register 0 holds the line length in pixels in bits [11:0] and the hsync width in bits [27:16]; the horizontal position runs 0 to length-1, and hsync is asserted while it is below the width.
- R3: Register 1 holds the frame length in pixel clocks and register 2 the vsync length in pixel clocks; the frame position runs 0 to length-1 and then returns to 0 with the horizontal position, and vsync is asserted while the frame position is below the vsync length.
- R4: de is 1 only when the frame position lies in the inclusive range [register 3, register 4] and the horizontal position lies in the inclusive range [register 5 bits [11:0], register 5 bits [27:16]].
- R5: Register 7 (skew) is added to both vertical bounds of R4.
- R6: Register 6 bit 0 makes hsync active-low and bit 1 makes vsync active-low; with a bit clear the sync is active-high, and an idle engine holds each sync at its inactive level.
- R7: While de is 1, pix_out is pix_in when pix_valid is 1; otherwise pix_sel is 1 and pix_out is the fill colour in register 8, which takes effect on the cycle after the write. While de is 0, pix_sel and pix_out are 0.
- R8: While running, writes to registers 0 to 7 do not change the current frame and take effect from the next frame.
- R9: Register 9 bit 0 is the enable; a change is honoured only when the frame position returns to 0 (or at once when idle), the first frame then starting at position 0, and an idle engine keeps de low.
- R10: Register 10 bit 0 lets frame_count increase by one per completed frame; bit 1 lets line_count increase by one per completed line; line_count clears at each frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | 32 | Register write value |
| pix_in | input | 24 | Pixel from the upstream source |
| pix_valid | input | 1 | Upstream pixel present this cycle |
| hsync | output | 1 | Horizontal sync at programmed polarity |
| vsync | output | 1 | Vertical sync at programmed polarity |
| de | output | 1 | Data enable, high inside the visible window |
| pix_sel | output | 1 | 1 when the fill colour replaces missing data |
| pix_out | output | 24 | Pixel towards the display |
| frame_count | output | 16 | Completed frames while counting enabled |
| line_count | output | 16 | Completed lines in the current frame |

## Verification
The assertions assume a nonzero line length and frame length are programmed before the enable bit is set, and that reset is held for at least two clocks so the previous-cycle terms start from known values. The stimulus writes a complete, legal mode while the engine is idle, changes timing only mid-frame or while idle, and never programs a zero period while running. Shadow and boundary behaviour are probed by writing in one frame and observing the outputs both later in that frame and in the next.

// File: rtl/ptg_pkg.sv
// Package: register indices and field positions shared by the timing
// generator modules and its bench. Assumes the write port index is at
// least 4 bits wide.
package ptg_pkg;
    localparam int REG_HTIME  = 0;   // line length / hsync width
    localparam int REG_VPER   = 1;   // frame length in pixel clocks
    localparam int REG_VSLEN  = 2;   // vsync length in pixel clocks
    localparam int REG_VFIRST = 3;   // first visible frame position
    localparam int REG_VLAST  = 4;   // last visible frame position
    localparam int REG_HWIN   = 5;   // visible pixel range in a line
    localparam int REG_POL    = 6;   // sync polarity bits
    localparam int REG_SKEW   = 7;   // added to vertical bounds
    localparam int REG_FILL   = 8;   // fill colour for missing data
    localparam int REG_ENABLE = 9;   // engine enable
    localparam int REG_CNTEN  = 10;  // counter enables

    localparam int HI_FIELD_LSB = 16;  // upper packed field position
    localparam int POL_H_BIT    = 0;
    localparam int POL_V_BIT    = 1;
    localparam int CNT_FRM_BIT  = 0;
    localparam int CNT_LIN_BIT  = 1;
    localparam int FILL_RESET   = 8'hFF;
endpackage

// File: rtl/ptg_regs.sv
// Register file: shadow copies written by the port, and a working set of
// timing registers that loads from the shadows on frame_load. The fill
// colour, counter enables and enable bit act from the shadow directly.
// Assumes DW covers HI_FIELD_LSB+HW, FW and PW bits.
module ptg_regs #(
    parameter int HW = 12,
    parameter int FW = 24,
    parameter int PW = 24,
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          frame_load,
    output logic [HW-1:0] act_hlen,
    output logic [HW-1:0] act_hpw,
    output logic [HW-1:0] act_hfirst,
    output logic [HW-1:0] act_hlast,
    output logic [FW-1:0] act_vper,
    output logic [FW-1:0] act_vslen,
    output logic [FW-1:0] act_vfirst,
    output logic [FW-1:0] act_vlast,
    output logic [FW-1:0] act_skew,
    output logic [1:0]    act_pol,
    output logic [PW-1:0] fill_color,
    output logic          sh_enable,
    output logic [1:0]    cnt_en
);
    import ptg_pkg::*;

    localparam int HI_MSB = HI_FIELD_LSB + HW - 1;

    logic [HW-1:0] sh_hlen, sh_hpw, sh_hfirst, sh_hlast;
    logic [FW-1:0] sh_vper, sh_vslen, sh_vfirst, sh_vlast, sh_skew;
    logic [1:0]    sh_pol;

    // Bits of the write word that no register stores.
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DW-1:HI_MSB+1], wr_data[HI_FIELD_LSB-1:HW]};

    // Shadow write port: one register per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hlen <= '0; sh_hpw <= '0; sh_hfirst <= '0; sh_hlast <= '0;
            sh_vper <= '0; sh_vslen <= '0; sh_vfirst <= '0; sh_vlast <= '0;
            sh_skew <= '0; sh_pol <= '0; sh_enable <= 1'b0; cnt_en <= '0;
            fill_color <= PW'(FILL_RESET);
        end else if (wr_en) begin
            case (wr_addr)
                AW'(REG_HTIME): begin
                    sh_hlen <= wr_data[HW-1:0];
                    sh_hpw  <= wr_data[HI_MSB:HI_FIELD_LSB];
                end
                AW'(REG_VPER):   sh_vper   <= wr_data[FW-1:0];
                AW'(REG_VSLEN):  sh_vslen  <= wr_data[FW-1:0];
                AW'(REG_VFIRST): sh_vfirst <= wr_data[FW-1:0];
                AW'(REG_VLAST):  sh_vlast  <= wr_data[FW-1:0];
                AW'(REG_HWIN): begin
                    sh_hfirst <= wr_data[HW-1:0];
                    sh_hlast  <= wr_data[HI_MSB:HI_FIELD_LSB];
                end
                AW'(REG_POL):    sh_pol     <= wr_data[1:0];
                AW'(REG_SKEW):   sh_skew    <= wr_data[FW-1:0];
                AW'(REG_FILL):   fill_color <= wr_data[PW-1:0];
                AW'(REG_ENABLE): sh_enable  <= wr_data[0];
                AW'(REG_CNTEN):  cnt_en     <= wr_data[1:0];
                default: ;
            endcase
        end
    end

    // Working set: copies the shadows only at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hlen <= '0; act_hpw <= '0; act_hfirst <= '0; act_hlast <= '0;
            act_vper <= '0; act_vslen <= '0; act_vfirst <= '0; act_vlast <= '0;
            act_skew <= '0; act_pol <= '0;
        end else if (frame_load) begin
            act_hlen <= sh_hlen; act_hpw <= sh_hpw;
            act_hfirst <= sh_hfirst; act_hlast <= sh_hlast;
            act_vper <= sh_vper; act_vslen <= sh_vslen;
            act_vfirst <= sh_vfirst; act_vlast <= sh_vlast;
            act_skew <= sh_skew; act_pol <= sh_pol;
        end
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_load |=> ($stable(act_hlen) && $stable(act_vper) && $stable(act_pol) && $stable(act_vfirst))); // R8
endmodule

// File: rtl/ptg_counters.sv
// Scan position and run control. The frame position counts pixel clocks
// from 0 to vper-1; the horizontal position wraps every hlen clocks.
// frame_load marks the cycle whose edge starts a frame (every cycle while
// idle). Assumes nonzero hlen and vper whenever the engine runs.
module ptg_counters #(
    parameter int HW = 12,
    parameter int FW = 24,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hlen,
    input  logic [FW-1:0] vper,
    input  logic          sh_enable,
    input  logic [1:0]    cnt_en,
    output logic          run,
    output logic [HW-1:0] hpos,
    output logic [FW-1:0] fpos,
    output logic          frame_load,
    output logic [CW-1:0] frame_count,
    output logic [CW-1:0] line_count
);
    import ptg_pkg::*;

    localparam logic [HW-1:0] H_ONE = HW'(1);
    localparam logic [FW-1:0] F_ONE = FW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    logic line_end;

    // Boundary detection for the line and the frame.
    always_comb begin
        line_end   = (hpos == hlen - H_ONE);
        frame_load = !run || (fpos == vper - F_ONE);
    end

    // Position, run flag and counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; hpos <= '0; fpos <= '0;
            frame_count <= '0; line_count <= '0;
        end else if (frame_load) begin
            run <= sh_enable;
            hpos <= '0;
            fpos <= '0;
            line_count <= '0;
            if (run && cnt_en[CNT_FRM_BIT]) frame_count <= frame_count + C_ONE;
        end else begin
            fpos <= fpos + F_ONE;
            if (line_end) begin
                hpos <= '0;
                if (cnt_en[CNT_LIN_BIT]) line_count <= line_count + C_ONE;
            end else begin
                hpos <= hpos + H_ONE;
            end
        end
    end

    AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hlen != '0) |-> (hpos < hlen)); // R2
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fpos == vper - F_ONE) |=> (fpos == '0 && hpos == '0)); // R3
    AST_IDLE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (fpos == '0 && hpos == '0)); // R9
    AST_RUN_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (run != $past(run)) |-> $past(frame_load)); // R9
    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count != $past(frame_count)) |-> (frame_count == $past(frame_count) + C_ONE)); // R10
endmodule

// File: rtl/ptg_outputs.sv
// Window decode and pixel path: derives sync strobes at their programmed
// polarity, the data enable from inclusive windows, and replaces missing
// pixels with the fill colour. Purely combinational from the scan state.
module ptg_outputs #(
    parameter int HW = 12,
    parameter int FW = 24,
    parameter int PW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [HW-1:0] hpos,
    input  logic [FW-1:0] fpos,
    input  logic [HW-1:0] hpw,
    input  logic [HW-1:0] hfirst,
    input  logic [HW-1:0] hlast,
    input  logic [FW-1:0] vslen,
    input  logic [FW-1:0] vfirst,
    input  logic [FW-1:0] vlast,
    input  logic [FW-1:0] skew,
    input  logic [1:0]    pol,
    input  logic [PW-1:0] pix_in,
    input  logic          pix_valid,
    input  logic [PW-1:0] fill_color,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_sel,
    output logic [PW-1:0] pix_out
);
    import ptg_pkg::*;

    logic [FW-1:0] v_lo, v_hi;
    logic          in_v, in_h, hs_on, vs_on;

    // Visible window and sync pulse decode.
    always_comb begin
        v_lo  = vfirst + skew;
        v_hi  = vlast + skew;
        in_v  = (fpos >= v_lo) && (fpos <= v_hi);
        in_h  = (hpos >= hfirst) && (hpos <= hlast);
        hs_on = run && (hpos < hpw);
        vs_on = run && (fpos < vslen);
        de    = run && in_v && in_h;
        hsync = hs_on ^ pol[POL_H_BIT];
        vsync = vs_on ^ pol[POL_V_BIT];
    end

    // Pixel selection between upstream data and fill colour.
    always_comb begin
        pix_sel = de && !pix_valid;
        if (!de)           pix_out = '0;
        else if (pix_valid) pix_out = pix_in;
        else               pix_out = fill_color;
    end

    AST_FILL_SUBST: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sel |-> (pix_out == fill_color)); // R7
    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (de && pix_valid) |-> (pix_out == pix_in && !pix_sel)); // R7
endmodule

// File: rtl/pixclk_timing_gen.sv
// Top level: register file, scan counters and output decode. Vertical
// timing is expressed in pixel clocks from the frame start. Assumes a
// legal mode (nonzero periods) is written before the enable bit is set.
module pixclk_timing_gen #(
    parameter int HW = 12,
    parameter int FW = 24,
    parameter int PW = 24,
    parameter int CW = 16,
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] pix_in,
    input  logic          pix_valid,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_sel,
    output logic [PW-1:0] pix_out,
    output logic [CW-1:0] frame_count,
    output logic [CW-1:0] line_count
);
    logic [HW-1:0] a_hlen, a_hpw, a_hfirst, a_hlast, hpos;
    logic [FW-1:0] a_vper, a_vslen, a_vfirst, a_vlast, a_skew, fpos;
    logic [1:0]    a_pol, cnt_en;
    logic [PW-1:0] fill_color;
    logic          sh_enable, run, frame_load;

    ptg_regs #(.HW(HW), .FW(FW), .PW(PW), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_load(frame_load),
        .act_hlen(a_hlen), .act_hpw(a_hpw), .act_hfirst(a_hfirst),
        .act_hlast(a_hlast), .act_vper(a_vper), .act_vslen(a_vslen),
        .act_vfirst(a_vfirst), .act_vlast(a_vlast), .act_skew(a_skew),
        .act_pol(a_pol), .fill_color(fill_color), .sh_enable(sh_enable),
        .cnt_en(cnt_en)
    );

    ptg_counters #(.HW(HW), .FW(FW), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hlen(a_hlen), .vper(a_vper),
        .sh_enable(sh_enable), .cnt_en(cnt_en), .run(run), .hpos(hpos),
        .fpos(fpos), .frame_load(frame_load), .frame_count(frame_count),
        .line_count(line_count)
    );

    ptg_outputs #(.HW(HW), .FW(FW), .PW(PW)) u_out (
        .clk(clk), .rst_n(rst_n), .run(run), .hpos(hpos), .fpos(fpos),
        .hpw(a_hpw), .hfirst(a_hfirst), .hlast(a_hlast), .vslen(a_vslen),
        .vfirst(a_vfirst), .vlast(a_vlast), .skew(a_skew), .pol(a_pol),
        .pix_in(pix_in), .pix_valid(pix_valid), .fill_color(fill_color),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_sel(pix_sel),
        .pix_out(pix_out)
    );
endmodule

// File: tb/pixclk_timing_gen_bench.sv
module pixclk_timing_gen_bench;
    import ptg_pkg::*;

    localparam int FRAME = 60;
    localparam logic [23:0] PIN = 24'hA5C3E1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [23:0] pix_in = PIN;
    logic        pix_valid = 1'b0;
    logic        hsync, vsync, de, pix_sel;
    logic [23:0] pix_out;
    logic [15:0] frame_count, line_count;

    int nchk = 0;
    int nfail = 0;
    int kpos = 0;

    always #4 clk = ~clk;

    pixclk_timing_gen u_pixclk_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pix_in(pix_in), .pix_valid(pix_valid),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_sel(pix_sel),
        .pix_out(pix_out), .frame_count(frame_count), .line_count(line_count)
    );

    // Mode: line 10, hsync 2, frame 60, vsync 10, rows 15..44, pixels 3..7.
    // Entry: {frame position, pix_valid, hsync, vsync, de, pix_sel}.
    localparam logic [12:0] VEC [0:12] = '{
        {8'd0,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'd2,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd9,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd13, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd15, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd17, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd18, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd23, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'd45, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd59, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        kpos = (kpos + 1) % FRAME;
    endtask

    task automatic go_to(input int k);
        while (kpos != k) step();
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic start_engine();
        wr(REG_ENABLE, 32'd1);
        step();
        kpos = 0;
    endtask

    task automatic probe(input int k, input logic v);
        go_to(k);
        pix_valid = v;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        // R1: reset state
        chk("R1", "hsync", 32'(hsync), 0);
        chk("R1", "vsync", 32'(vsync), 0);
        chk("R1", "de", 32'(de), 0);
        chk("R1", "pix_out", 32'(pix_out), 0);
        chk("R1", "frame_count", 32'(frame_count), 0);
        chk("R1", "line_count", 32'(line_count), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();

        wr(REG_HTIME, 32'h0002_000A);
        wr(REG_VPER, 32'd60);
        wr(REG_VSLEN, 32'd10);
        wr(REG_VFIRST, 32'd15);
        wr(REG_VLAST, 32'd44);
        wr(REG_HWIN, 32'h0007_0003);
        wr(REG_CNTEN, 32'd3);
        // R1 R9: idle engine keeps outputs quiet after programming
        #1;
        chk("R9", "idle de", 32'(de), 0);
        chk("R9", "idle vsync", 32'(vsync), 0);
        start_engine();

        // Table walk over frame 0: R2 R3 R4 R7, fill colour at reset value (R1)
        for (int i = 0; i < 13; i++) begin
            logic [12:0] e;
            e = VEC[i];
            probe(int'(e[12:5]), e[4]);
            chk("R2", "hsync", 32'(hsync), 32'(e[3]));
            chk("R3", "vsync", 32'(vsync), 32'(e[2]));
            chk("R4", "de", 32'(de), 32'(e[1]));
            chk("R7", "pix_sel", 32'(pix_sel), 32'(e[0]));
            chk("R1", "pix_out", 32'(pix_out),
                e[1] ? (e[4] ? 32'(PIN) : 32'h0000_00FF) : 32'd0);
            if (e[12:5] == 8'd23) chk("R10", "line_count mid", 32'(line_count), 2);
            if (e[12:5] == 8'd59) chk("R10", "line_count end", 32'(line_count), 5);
        end

        // R3: frame wrap back to position 0
        probe(0, 1'b0);
        chk("R3", "wrap hsync", 32'(hsync), 1);
        chk("R3", "wrap vsync", 32'(vsync), 1);
        chk("R10", "frame_count", 32'(frame_count), 1);
        chk("R10", "line_count clear", 32'(line_count), 0);

        // R8: mid-frame writes do not disturb frame 1
        go_to(30);
        wr(REG_HTIME, 32'h0004_000A);
        wr(REG_POL, 32'd3);
        probe(43, 1'b1);
        chk("R8", "hsync same frame", 32'(hsync), 0);
        probe(45, 1'b1);
        chk("R8", "vsync same frame", 32'(vsync), 0);
        // R6 R8: frame 2 uses wider hsync and active-low syncs
        probe(0, 1'b1);
        probe(5, 1'b1);
        chk("R6", "hsync inactive low-pol", 32'(hsync), 1);
        chk("R6", "vsync active low-pol", 32'(vsync), 0);
        probe(13, 1'b1);
        chk("R8", "hsync new width active", 32'(hsync), 0);
        probe(15, 1'b1);
        chk("R6", "vsync inactive low-pol", 32'(vsync), 1);
        chk("R10", "frame_count 2", 32'(frame_count), 2);

        wr(REG_POL, 32'd0);
        wr(REG_HTIME, 32'h0002_000A);
        wr(REG_FILL, 32'h0012_3456);
        wr(REG_CNTEN, 32'd2);
        // R7: new fill colour acts at once
        probe(25, 1'b0);
        chk("R7", "fill pix_out", 32'(pix_out), 32'h0012_3456);
        chk("R7", "fill pix_sel", 32'(pix_sel), 1);
        pix_valid = 1'b1; #1;
        chk("R7", "pass pix_out", 32'(pix_out), 32'(PIN));
        probe(26, 1'b0);
        chk("R6", "pending pol unchanged", 32'(hsync), 1);

        // R10: frame counting off across the boundary into frame 3
        probe(0, 1'b0);
        probe(1, 1'b0);
        chk("R10", "frame_count held", 32'(frame_count), 2);
        chk("R6", "restored hsync", 32'(hsync), 1);
        wr(REG_CNTEN, 32'd1);
        probe(35, 1'b0);
        chk("R10", "line_count held", 32'(line_count), 0);

        // R9: disable finishes the current frame
        wr(REG_ENABLE, 32'd0);
        probe(50, 1'b0);
        chk("R9", "still running hsync", 32'(hsync), 1);
        chk("R9", "still running vsync", 32'(vsync), 0);
        go_to(59);
        repeat (6) step();
        #1;
        chk("R9", "stopped vsync", 32'(vsync), 0);
        chk("R9", "stopped hsync", 32'(hsync), 0);
        chk("R9", "stopped de", 32'(de), 0);
        chk("R10", "frame_count final", 32'(frame_count), 3);

        // R5: skew shifts the vertical window by 5
        wr(REG_SKEW, 32'd5);
        start_engine();
        probe(15, 1'b1);
        chk("R5", "de before shifted start", 32'(de), 0);
        probe(23, 1'b1);
        chk("R5", "de inside", 32'(de), 1);
        probe(47, 1'b1);
        chk("R5", "de past old end", 32'(de), 1);
        probe(53, 1'b1);
        chk("R5", "de after shifted end", 32'(de), 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule